// File: doc/BRIEF.md
# Dual-Channel Multiplexed Converter Output Stage

This block is the digital back end of a two-channel converter. A pair of corrected 10-bit results, one for channel A and one for channel B, is taken in on the same sample instant. The pair travels through a fixed-latency alignment line and is then placed on a single shared 10-bit bus: first the channel A word, then, half a sample period later, the channel B word. A flag output tells the receiver which channel currently occupies the bus.

The block runs on a clock at twice the sample rate. A phase input, high during the 2x-clock cycle that corresponds to the rising sample-clock edge, marks which ticks stand for rising and which for falling sample edges. Input results arrive in offset binary. A format input selects whether the bus carries them unchanged or in two's complement. An active-low output enable gates a per-bit drive-enable vector, which a pad wrapper resolves to high impedance. Power-down freezes the bus at its last value. Sleep stops new samples from being taken. Both of them empty the alignment line, so no stale result appears once they are released.

Top module: `dmx_out_stage`

## Requirements
- R1: A pair taken on a clock edge with `rise_ph`=1 and `samp_vld`=1 puts its A word on `bus_q` at the edge 2*LAT clock edges later (10 with LAT=5). The B word follows at the next edge. The bus does not change before then.
- R2: `chan_a` is 1 while an A word is on the bus and 0 while a B word is on the bus.
- R3: Input codes are offset binary. With `fmt_twos`=0 a word is driven unchanged. With `fmt_twos`=1 its bit 9 is inverted and bits 8..0 are unchanged. The format is taken at the edge that loads the bus.
- R4: Input 0x200 (mid-scale) appears as 0x200 in offset binary and as 0x000 in two's complement. Input 0x000 (negative full scale) appears as 0x000 and as 0x200 respectively.
- R5: One edge after `oe_n` is sampled high, `bus_drv` is all zeros. One edge after it is sampled low, `bus_drv` is all ones. The held value of `bus_q` is not altered by `oe_n`.
- R6: At every edge where `pd` is high, `bus_q` and `chan_a` keep their values.
- R7: At every edge where `sleep` is high, no pair is taken and `bus_q` keeps its value.
- R8: An edge with `pd` or `sleep` high discards every pair in flight. After release, only pairs taken later reach the bus, each with the R1 latency.
- R9: While `rst` is high, `bus_q` is 0, `chan_a` is 0 and `bus_drv` is 0.
- R10: With `samp_vld` low, or on ticks with `rise_ph` low, no pair is taken, and the bus holds its last word once the line is empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 2x sample-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| rise_ph | input | 1 | High on the tick that stands for the rising sample edge |
| samp_vld | input | 1 | Input pair is valid |
| a_code | input | 10 | Channel A result, offset binary |
| b_code | input | 10 | Channel B result, offset binary |
| fmt_twos | input | 1 | 1 = two's complement, 0 = offset binary |
| oe_n | input | 1 | Active-low output enable |
| pd | input | 1 | Power-down: freeze and flush |
| sleep | input | 1 | Sleep: stop sampling and flush |
| bus_q | output | 10 | Shared multiplexed data bus |
| bus_drv | output | 10 | Per-bit drive enable (0 = high impedance) |
| chan_a | output | 1 | 1 = channel A word on bus, 0 = channel B |

## Verification
The hardest situation to reach is power-down arriving between the A and B halves of one pair, while further pairs are still in the alignment line. The stimulus streams several consecutive pairs and raises `pd` on the exact tick where the second pair's B word would load. It holds `pd` for several sample periods and then releases it with no new data. The bus must keep showing the second pair's A word and must never show any word that was already in flight. A single pair sent afterwards then confirms that the line refills with the full latency.

// File: rtl/dmx_pkg.sv
package dmx_pkg;
  localparam int CODE_W  = 10;
  localparam int LAT_CYC = 5;

  typedef enum logic {
    CH_B = 1'b0,
    CH_A = 1'b1
  } chan_e;
endpackage

// File: rtl/dmx_align_line.sv
module dmx_align_line #(
  parameter int W     = dmx_pkg::CODE_W,
  parameter int DEPTH = dmx_pkg::LAT_CYC
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift,
  input  logic         cap_en,
  input  logic         flush,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic         tail_vld,
  output logic [W-1:0] tail_a,
  output logic [W-1:0] tail_b
);
  localparam int LAST = DEPTH - 1;

  logic [DEPTH-1:0] vld_q;
  logic [W-1:0]     a_q [DEPTH];
  logic [W-1:0]     b_q [DEPTH];

  // Valid bits: cleared on reset or flush, advance on rising-phase ticks.
  always_ff @(posedge clk) begin
    if (rst || flush)
      vld_q <= '0;
    else if (shift)
      vld_q <= {vld_q[DEPTH-2:0], cap_en};
  end

  // Data stages carry no reset.
  generate
    for (genvar s = 0; s < DEPTH; s++) begin : g_stage
      if (s == 0) begin : g_head
        always_ff @(posedge clk) begin
          if (shift && cap_en) begin
            a_q[0] <= a_in;
            b_q[0] <= b_in;
          end
        end
      end else begin : g_body
        always_ff @(posedge clk) begin
          if (shift) begin
            a_q[s] <= a_q[s-1];
            b_q[s] <= b_q[s-1];
          end
        end
      end
    end
  endgenerate

  assign tail_vld = vld_q[LAST];
  assign tail_a   = a_q[LAST];
  assign tail_b   = b_q[LAST];

  // R8: a flush empties the whole line
  a_r8_flush_empties: assert property (@(posedge clk) disable iff (rst)
    flush |=> ($countones(vld_q) == 0));

  // R10: a tick that takes no pair inserts an empty slot
  a_r10_no_capture: assert property (@(posedge clk) disable iff (rst)
    (shift && !cap_en) |=> !vld_q[0]);
endmodule

// File: rtl/dmx_bus_reg.sv
module dmx_bus_reg #(
  parameter int W = dmx_pkg::CODE_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         rise_ph,
  input  logic         hold,
  input  logic         fmt_twos,
  input  logic         oe_n,
  input  logic         tail_vld,
  input  logic [W-1:0] tail_a,
  input  logic [W-1:0] tail_b,
  output logic [W-1:0] bus_q,
  output logic [W-1:0] bus_drv,
  output logic         chan_a
);
  import dmx_pkg::*;

  localparam int MSB = W - 1;

  chan_e        flag_q;
  logic [W-1:0] pend_b;
  logic         pend_vld;
  logic         ld_a;
  logic         ld_b;

  function automatic logic [W-1:0] recode(input logic [W-1:0] c, input logic twos);
    logic [W-1:0] r;
    r      = c;
    r[MSB] = c[MSB] ^ twos;
    return r;
  endfunction

  assign ld_a = rise_ph && tail_vld && !hold;
  assign ld_b = !rise_ph && pend_vld && !hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_q    <= '0;
      flag_q   <= CH_B;
      pend_vld <= 1'b0;
    end else if (hold) begin
      pend_vld <= 1'b0;
    end else if (ld_a) begin
      bus_q    <= recode(tail_a, fmt_twos);
      flag_q   <= CH_A;
      pend_vld <= 1'b1;
    end else if (ld_b) begin
      bus_q    <= recode(pend_b, fmt_twos);
      flag_q   <= CH_B;
      pend_vld <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (ld_a)
      pend_b <= tail_b;
  end

  always_ff @(posedge clk) begin
    if (rst)
      bus_drv <= '0;
    else
      bus_drv <= {W{!oe_n}};
  end

  assign chan_a = (flag_q == CH_A);

  // R2: flag follows the channel that was loaded
  a_r2_flag_a: assert property (@(posedge clk) disable iff (rst)
    ld_a |=> chan_a);
  a_r2_flag_b: assert property (@(posedge clk) disable iff (rst)
    ld_b |=> !chan_a);

  // R5: output enable gates every drive bit
  a_r5_drive_off: assert property (@(posedge clk) disable iff (rst)
    oe_n |=> (bus_drv == '0));
  a_r5_drive_on: assert property (@(posedge clk) disable iff (rst)
    !oe_n |=> (bus_drv == {W{1'b1}}));
endmodule

// File: rtl/dmx_out_stage.sv
module dmx_out_stage #(
  parameter int W   = dmx_pkg::CODE_W,
  parameter int LAT = dmx_pkg::LAT_CYC
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         rise_ph,
  input  logic         samp_vld,
  input  logic [W-1:0] a_code,
  input  logic [W-1:0] b_code,
  input  logic         fmt_twos,
  input  logic         oe_n,
  input  logic         pd,
  input  logic         sleep,
  output logic [W-1:0] bus_q,
  output logic [W-1:0] bus_drv,
  output logic         chan_a
);
  logic         quiet;
  logic         cap_en;
  logic         tail_vld;
  logic [W-1:0] tail_a;
  logic [W-1:0] tail_b;

  assign quiet  = pd || sleep;
  assign cap_en = rise_ph && samp_vld && !quiet;

  dmx_align_line #(.W(W), .DEPTH(LAT)) u_line (
    .clk      (clk),
    .rst      (rst),
    .shift    (rise_ph),
    .cap_en   (cap_en),
    .flush    (quiet),
    .a_in     (a_code),
    .b_in     (b_code),
    .tail_vld (tail_vld),
    .tail_a   (tail_a),
    .tail_b   (tail_b)
  );

  dmx_bus_reg #(.W(W)) u_bus (
    .clk      (clk),
    .rst      (rst),
    .rise_ph  (rise_ph),
    .hold     (quiet),
    .fmt_twos (fmt_twos),
    .oe_n     (oe_n),
    .tail_vld (tail_vld),
    .tail_a   (tail_a),
    .tail_b   (tail_b),
    .bus_q    (bus_q),
    .bus_drv  (bus_drv),
    .chan_a   (chan_a)
  );

  // R6: power-down freezes bus and flag
  a_r6_pd_freeze: assert property (@(posedge clk) disable iff (rst)
    pd |=> ($stable(bus_q) && $stable(chan_a)));

  // R7: sleep keeps the bus unchanged
  a_r7_sleep_hold: assert property (@(posedge clk) disable iff (rst)
    sleep |=> $stable(bus_q));
endmodule

// File: tb/dmx_out_stage_test.sv
module dmx_out_stage_test;
  localparam int W   = 10;
  localparam int LAT = 5;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         rise_ph = 1'b0;
  logic         samp_vld = 1'b0;
  logic [W-1:0] a_code = '0;
  logic [W-1:0] b_code = '0;
  logic         fmt_twos = 1'b0;
  logic         oe_n = 1'b0;
  logic         pd = 1'b0;
  logic         sleep = 1'b0;
  logic [W-1:0] bus_q;
  logic [W-1:0] bus_drv;
  logic         chan_a;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  dmx_out_stage #(.W(W), .LAT(LAT)) uut (
    .clk(clk), .rst(rst), .rise_ph(rise_ph), .samp_vld(samp_vld),
    .a_code(a_code), .b_code(b_code), .fmt_twos(fmt_twos), .oe_n(oe_n),
    .pd(pd), .sleep(sleep), .bus_q(bus_q), .bus_drv(bus_drv), .chan_a(chan_a)
  );

  always #4 clk = ~clk;

  function automatic logic [W-1:0] enc(input logic [W-1:0] x, input logic f);
    return f ? {~x[W-1], x[W-2:0]} : x;
  endfunction
  function automatic logic [W-1:0] va(input int seed, input int k);
    return W'((seed + k * 73) % 1024);
  endfunction
  function automatic logic [W-1:0] vb(input int seed, input int k);
    return W'((seed * 3 + k * 151 + 5) % 1024);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic r, input logic v, input logic [W-1:0] a, input logic [W-1:0] b);
    rise_ph = r; samp_vld = v; a_code = a; b_code = b;
    @(posedge clk);
    #1;
  endtask

  task automatic idle(input int pairs);
    for (int i = 0; i < pairs; i++) begin
      step(1'b1, 1'b0, '0, '0);
      step(1'b0, 1'b0, '0, '0);
    end
  endtask

  // R9: reset values
  task automatic t_reset;
    rst = 1'b1;
    idle(2);
    check("R9 bus", 32'(bus_q), 32'h0);
    check("R9 flag", 32'(chan_a), 32'h0);
    check("R9 drv", 32'(bus_drv), 32'h0);
    rst = 1'b0;
    idle(1);
  endtask

  // R1, R2, R3, R10: stream of n consecutive pairs
  task automatic t_stream(input int n, input int seed, input logic f);
    logic [W-1:0] start_bus;
    start_bus = bus_q;
    fmt_twos = f;
    for (int c = 0; c < 2 * (n + LAT) + 2; c++) begin
      int k;
      k = c / 2;
      if (c % 2 == 0) step(1'b1, k < n, va(seed, k), vb(seed, k));
      else            step(1'b0, 1'b0, '0, '0);
      if (c < 2 * LAT) begin
        check("R1 early", 32'(bus_q), 32'(start_bus));
      end else if (c % 2 == 0 && (c - 2 * LAT) / 2 < n) begin
        check("R1/R3 A word", 32'(bus_q), 32'(enc(va(seed, (c - 2 * LAT) / 2), f)));
        check("R2 flag A", 32'(chan_a), 32'h1);
      end else if (c % 2 == 1 && (c - 2 * LAT - 1) / 2 < n) begin
        check("R1/R3 B word", 32'(bus_q), 32'(enc(vb(seed, (c - 2 * LAT - 1) / 2), f)));
        check("R2 flag B", 32'(chan_a), 32'h0);
      end else begin
        check("R10 hold", 32'(bus_q), 32'(enc(vb(seed, n - 1), f)));
      end
    end
  endtask

  // R4, R8: one pair, checked at the exact latency
  task automatic t_single(input logic [W-1:0] a, input logic [W-1:0] b, input logic f,
                          input logic [W-1:0] ea, input logic [W-1:0] eb, input string req);
    logic [W-1:0] start_bus;
    start_bus = bus_q;
    fmt_twos = f;
    for (int c = 0; c < 2 * LAT + 2; c++) begin
      if (c % 2 == 0) step(1'b1, c == 0, a, b);
      else            step(1'b0, 1'b0, '0, '0);
      if (c < 2 * LAT)       check({req, " early"}, 32'(bus_q), 32'(start_bus));
      else if (c == 2 * LAT) check({req, " A"}, 32'(bus_q), 32'(ea));
      else                   check({req, " B"}, 32'(bus_q), 32'(eb));
    end
  endtask

  // R5: output enable
  task automatic t_oe;
    logic [W-1:0] held;
    held = bus_q;
    oe_n = 1'b1;
    step(1'b1, 1'b0, '0, '0);
    check("R5 drive off", 32'(bus_drv), 32'h0);
    step(1'b0, 1'b0, '0, '0);
    idle(1);
    check("R5 value kept", 32'(bus_q), 32'(held));
    oe_n = 1'b0;
    step(1'b1, 1'b0, '0, '0);
    check("R5 drive on", 32'(bus_drv), 32'h3FF);
    step(1'b0, 1'b0, '0, '0);
    check("R5 value after", 32'(bus_q), 32'(held));
  endtask

  // R6, R8: power-down between the A and B halves of the second pair
  task automatic t_pd;
    int seed;
    seed = 211;
    fmt_twos = 1'b0;
    for (int c = 0; c < 44; c++) begin
      int k;
      k = c / 2;
      pd = (c >= 2 * LAT + 3) && (c <= 2 * LAT + 10);
      if (c % 2 == 0) step(1'b1, k < 6, va(seed, k), vb(seed, k));
      else            step(1'b0, 1'b0, '0, '0);
      if (c == 2 * LAT)          check("R1 pd A0", 32'(bus_q), 32'(va(seed, 0)));
      else if (c == 2 * LAT + 1) check("R1 pd B0", 32'(bus_q), 32'(vb(seed, 0)));
      else if (c >= 2 * LAT + 2) begin
        check("R6/R8 frozen", 32'(bus_q), 32'(va(seed, 1)));
        check("R6 flag", 32'(chan_a), 32'h1);
      end
    end
    pd = 1'b0;
    t_single(10'h155, 10'h2AA, 1'b0, 10'h155, 10'h2AA, "R8 refill");
  endtask

  // R7: sleep blocks sampling
  task automatic t_sleep;
    logic [W-1:0] held;
    held = bus_q;
    sleep = 1'b1;
    for (int i = 0; i < 3; i++) begin
      step(1'b1, 1'b1, 10'h0F0, 10'h30F);
      step(1'b0, 1'b0, '0, '0);
      check("R7 hold in sleep", 32'(bus_q), 32'(held));
    end
    sleep = 1'b0;
    for (int i = 0; i < LAT + 2; i++) begin
      step(1'b1, 1'b0, '0, '0);
      step(1'b0, 1'b0, '0, '0);
      check("R7 nothing taken", 32'(bus_q), 32'(held));
    end
    t_single(10'h001, 10'h3FE, 1'b1, 10'h201, 10'h1FE, "R7 wake");
  endtask

  // R10: valid low while rise ticks continue
  task automatic t_novalid;
    logic [W-1:0] held;
    held = bus_q;
    for (int i = 0; i < LAT + 3; i++) begin
      step(1'b1, 1'b0, 10'h111, 10'h222);
      step(1'b0, 1'b1, 10'h333, 10'h044);
      check("R10 no capture", 32'(bus_q), 32'(held));
    end
  endtask

  task automatic report;
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    #1;
    t_reset();
    t_stream(6, 17, 1'b0);
    t_stream(4, 400, 1'b1);
    t_single(10'h200, 10'h000, 1'b0, 10'h200, 10'h000, "R4 offset");
    t_single(10'h200, 10'h000, 1'b1, 10'h000, 10'h200, "R4 twos");
    t_oe();
    t_pd();
    t_sleep();
    t_novalid();
    report();
  end
endmodule